// File: doc/BRIEF.md
# System Address Range Decoder

This block turns a physical address into a memory-controller number and a channel number inside one socket. Software first fills a table of range entries, one interleave-target word per entry, a packed route word and two memory-hole limits through a simple write port. A request then presents a 46-bit address. The block walks the range table in order until an enabled entry covers the address. It uses address bits chosen by that entry to pick a 4-bit target from the companion word. For a local target it forms a logical channel, optionally folding the address through a modulo-3 or modulo-2 rule, and reads the controller and channel fields for that logical channel out of the route word.

If the target points at another node, the block does not follow it. It returns a remote flag and the node number, and the caller continues the walk with that node's tables. Addresses that fall in the memory hole or above the top of memory are rejected before any table access. Only one request is in flight at a time. Each answer comes back as a single-cycle result pulse carrying an error code.

Top module: `sysaddr_decode`

## Requirements
- R1: A request whose address is at or above (high limit × 2^26), or at or above (low limit × 2^26) and below 2^32, completes with error code 1 (range) and all other result fields zero.
- R2: Entries are examined in index order and the first enabled entry whose window contains the address wins. Entry 0's window starts at 0 and each later window starts one past the previous entry's limit, even when that previous entry is disabled. A disabled entry never matches.
- R3: In an entry word, bit 0 enables the entry, and its limit is the 20-bit field in bits 26:7 shifted left by 26 with bits 25:0 all ones.
- R4: When no entry of the 24 matches, the result has error code 2 (no entry) and all other fields zero.
- R5: Entry bits 2:1 select the 3-bit interleave index: value 0 takes address bits 8:6, 1 takes 10:8, 2 takes 14:12 and 3 takes 32:30. The target is the nibble of the companion word starting at bit 4×index.
- R6: A target with bit 3 clear completes with error code 0, the remote flag set, the node equal to target bits 2:0, the matched entry index, and zero logical channel, controller and channel.
- R7: With entry bit 27 clear, a local target gives a logical channel equal to target bits 2:0.
- R8: With entry bit 27 set, entry bits 31:30 choose a shift of 6, 8 or 12 for values 0, 1 and 2. Value 3 completes with error code 3 and the matched entry index, all else zero.
- R9: With entry bit 27 set, let v be the address shifted right by the chosen shift. Entry bits 6:5 form the base: 0 gives v mod 3, 1 gives v mod 2, 2 gives 2 if v is odd else 1, and 3 gives 2×(v mod 2). The logical channel is base×2 plus target bit 0.
- R10: For logical channel L, the controller is route bits 3L+2:3L and the channel is route bits 2L+19:2L+18. Route bits above 31 read as zero.
- R11: req_ready is high only while the block is idle, so a second request is not taken until the first one has answered. rsp_valid lasts one cycle, and the result fields hold their values afterwards.
- R12: After reset, req_ready is 1, rsp_valid is 0 and every table word, the route word and both limits are zero. Writes use wr_kind 0 for an entry word, 1 for a target word, 2 for the route word, 3 for the low limit and 4 for the high limit. Each limit is wr_data bits 19:0 in units of 2^26 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind selected for the write |
| wr_idx | input | 5 | Entry index for entry and target writes |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Address request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 46 | Physical address to decode |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 2 | 0 ok, 1 range, 2 no entry, 3 bad fold mode |
| rsp_remote | output | 1 | Target belongs to another node |
| rsp_node | output | 3 | Remote node number |
| rsp_lch | output | 3 | Logical channel |
| rsp_mc | output | 3 | Memory-controller number |
| rsp_ch | output | 2 | Channel number within the controller |
| rsp_entry | output | 5 | Index of the matching entry |

## Verification
On every cycle the assertions check the request and result handshake. They check that the scan index only ever steps by one and stays inside the table, that a range error answers straight from the accepting cycle, that a remote answer never carries an error, and that the modulo-3 reducer's remainder stays legal. The bench has to show the arithmetic itself. It checks first-match order across a disabled entry and exact limit boundaries. It sweeps all interleave, fold-shift and fold sub-modes, and checks route field extraction for every logical channel. Each result is compared with a value the bench works out with integer division and remainder.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int AW     = 46;
    localparam int GRAN   = 26;
    localparam int LIM_W  = AW - GRAN;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RANGE = 2'd1,
        ERR_NOENT = 2'd2,
        ERR_MODE  = 2'd3
    } sad_err_e;

    typedef enum logic [2:0] {
        WK_ENT   = 3'd0,
        WK_TGT   = 3'd1,
        WK_ROUTE = 3'd2,
        WK_LOW   = 3'd3,
        WK_HIGH  = 3'd4
    } wr_kind_e;

    // Fields of a matched entry that later stages still need
    typedef struct packed {
        logic [1:0] fold;
        logic       m3;
        logic [1:0] sub;
        logic [1:0] ilv;
    } hit_f_t;

    typedef struct packed {
        logic [1:0] err;
        logic       remote;
        logic [2:0] node;
        logic [2:0] lch;
        logic [2:0] mc;
        logic [1:0] ch;
    } sad_res_t;
endpackage

// File: rtl/sad_regs.sv
module sad_regs
    import sad_pkg::*;
#(
    parameter int ENTRIES = 24,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_ent,
    output logic [WORD_W-1:0] rd_tgt,
    output logic [WORD_W-1:0] route,
    output logic [LIM_W-1:0]  low_gran,
    output logic [LIM_W-1:0]  high_gran
);
    logic [WORD_W-1:0] ent_q [ENTRIES];
    logic [WORD_W-1:0] ent_d [ENTRIES];
    logic [WORD_W-1:0] tgt_q [ENTRIES];
    logic [WORD_W-1:0] tgt_d [ENTRIES];
    logic [WORD_W-1:0] route_q, route_d;
    logic [LIM_W-1:0]  low_q, low_d, high_q, high_d;
    logic              idx_ok;

    assign idx_ok = (int'(wr_idx) < ENTRIES);

    always_comb begin
        ent_d   = ent_q;
        tgt_d   = tgt_q;
        route_d = route_q;
        low_d   = low_q;
        high_d  = high_q;
        if (wr_en) begin
            case (wr_kind_e'(wr_kind))
                WK_ENT:   if (idx_ok) ent_d[wr_idx] = wr_data;
                WK_TGT:   if (idx_ok) tgt_d[wr_idx] = wr_data;
                WK_ROUTE: route_d = wr_data;
                WK_LOW:   low_d   = wr_data[LIM_W-1:0];
                WK_HIGH:  high_d  = wr_data[LIM_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
                tgt_q[i] <= '0;
            end
            route_q <= '0;
            low_q   <= '0;
            high_q  <= '0;
        end else begin
            ent_q   <= ent_d;
            tgt_q   <= tgt_d;
            route_q <= route_d;
            low_q   <= low_d;
            high_q  <= high_d;
        end
    end

    assign rd_ent    = ent_q[rd_idx];
    assign rd_tgt    = tgt_q[rd_idx];
    assign route     = route_q;
    assign low_gran  = low_q;
    assign high_gran = high_q;

    // R12: a limit write lands on the next cycle
    assert_limit_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 3'd4) |=> (high_gran == $past(wr_data[LIM_W-1:0])));
endmodule

// File: rtl/sad_mod3.sv
module sad_mod3 #(
    parameter int W = 46,
    localparam int STEPS = (W + 1) / 2,
    localparam int CW = $clog2(STEPS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] val,
    output logic         done,
    output logic [1:0]   rem
);
    // 4^k is 1 mod 3, so the remainder is the digit sum of base-4 digits
    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
        logic [1:0]    rem;
        logic          busy;
        logic          done;
    } m3_t;

    m3_t q, d;
    logic [2:0] sum;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sum    = {1'b0, q.rem} + {1'b0, q.sr[1:0]};
        if (start) begin
            d.sr   = val;
            d.cnt  = '0;
            d.rem  = '0;
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.rem = (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
            d.sr  = q.sr >> 2;
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(STEPS - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign rem  = q.rem;

    assert_rem_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.rem != 2'd3);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy);
endmodule

// File: rtl/sad_pick.sv
module sad_pick
    import sad_pkg::*;
(
    input  hit_f_t            f,
    input  logic [WORD_W-1:0] tgt_word,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        m3_rem,
    input  logic [WORD_W-1:0] route,
    output logic              remote,
    output logic [2:0]        node,
    output logic              mode_err,
    output logic              need_m3,
    output logic [AW-1:0]     fold_val,
    output logic [2:0]        lch,
    output logic [2:0]        mc,
    output logic [1:0]        ch
);
    logic [2:0]  ilv_idx;
    logic [3:0]  nib;
    logic [1:0]  base;
    logic        v0;
    logic [63:0] route64;

    always_comb begin
        case (f.ilv)
            2'd0:    ilv_idx = addr[8:6];
            2'd1:    ilv_idx = addr[10:8];
            2'd2:    ilv_idx = addr[14:12];
            default: ilv_idx = addr[32:30];
        endcase
        nib = tgt_word[{ilv_idx, 2'b00} +: 4];

        case (f.fold)
            2'd0:    fold_val = addr >> 6;
            2'd1:    fold_val = addr >> 8;
            default: fold_val = addr >> 12;
        endcase
        v0 = fold_val[0];

        case (f.sub)
            2'd0:    base = m3_rem;
            2'd1:    base = {1'b0, v0};
            2'd2:    base = {v0, ~v0};
            default: base = {v0, 1'b0};
        endcase

        remote   = ~nib[3];
        node     = nib[2:0];
        mode_err = ~remote & f.m3 & (f.fold == 2'd3);
        need_m3  = ~remote & f.m3 & (f.fold != 2'd3) & (f.sub == 2'd0);
        lch      = f.m3 ? {base, nib[0]} : nib[2:0];

        route64 = {32'd0, route};
        mc      = route64[3 * lch +: 3];
        ch      = route64[2 * lch + 18 +: 2];
    end
endmodule

// File: rtl/sysaddr_decode.sv
module sysaddr_decode
    import sad_pkg::*;
#(
    parameter int ENTRIES = 24,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_err,
    output logic              rsp_remote,
    output logic [2:0]        rsp_node,
    output logic [2:0]        rsp_lch,
    output logic [2:0]        rsp_mc,
    output logic [1:0]        rsp_ch,
    output logic [IW-1:0]     rsp_entry
);
    localparam logic [AW-1:0] FOUR_G = AW'(64'h1_0000_0000);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EVAL, S_FOLD} st_e;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [AW-1:0] lo;
        logic [IW-1:0] idx;
        hit_f_t        hit;
        logic [WORD_W-1:0] htgt;
        sad_res_t      res;
        logic [IW-1:0] rent;
        logic          rvalid;
    } top_t;

    top_t q, d;

    logic [WORD_W-1:0] rd_ent, rd_tgt, route;
    logic [LIM_W-1:0]  low_gran, high_gran;
    logic [AW-1:0]     lim;
    logic              hit_now, out_rng;
    logic              p_remote, p_mode_err, p_need_m3;
    logic [2:0]        p_node, p_lch, p_mc;
    logic [1:0]        p_ch, m3_rem;
    logic [AW-1:0]     fold_val;
    logic              m3_start, m3_done;
    logic              unused_attr;

    sad_regs #(.ENTRIES(ENTRIES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(q.idx), .rd_ent(rd_ent), .rd_tgt(rd_tgt),
        .route(route), .low_gran(low_gran), .high_gran(high_gran)
    );

    sad_pick u_pick (
        .f(q.hit), .tgt_word(q.htgt), .addr(q.addr), .m3_rem(m3_rem),
        .route(route), .remote(p_remote), .node(p_node),
        .mode_err(p_mode_err), .need_m3(p_need_m3), .fold_val(fold_val),
        .lch(p_lch), .mc(p_mc), .ch(p_ch)
    );

    sad_mod3 #(.W(AW)) u_mod3 (
        .clk(clk), .rst_n(rst_n), .start(m3_start), .val(fold_val),
        .done(m3_done), .rem(m3_rem)
    );

    assign unused_attr = ^{rd_ent[4:3], rd_ent[29:28]};

    always_comb begin
        lim     = {rd_ent[26:7], {GRAN{1'b1}}};
        hit_now = rd_ent[0] && (q.addr >= q.lo) && (q.addr <= lim);
        out_rng = (req_addr >= {high_gran, {GRAN{1'b0}}}) ||
                  ((req_addr >= {low_gran, {GRAN{1'b0}}}) && (req_addr < FOUR_G));
    end

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        m3_start = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    if (out_rng) begin
                        d.res     = '0;
                        d.res.err = ERR_RANGE;
                        d.rent    = '0;
                        d.rvalid  = 1'b1;
                    end else begin
                        d.st  = S_SCAN;
                        d.idx = '0;
                        d.lo  = '0;
                    end
                end
            end
            S_SCAN: begin
                if (hit_now) begin
                    d.hit  = '{fold: rd_ent[31:30], m3: rd_ent[27],
                               sub: rd_ent[6:5], ilv: rd_ent[2:1]};
                    d.htgt = rd_tgt;
                    d.rent = q.idx;
                    d.st   = S_EVAL;
                end else if (q.idx == IW'(ENTRIES - 1)) begin
                    d.res     = '0;
                    d.res.err = ERR_NOENT;
                    d.rent    = '0;
                    d.rvalid  = 1'b1;
                    d.idx     = '0;
                    d.st      = S_IDLE;
                end else begin
                    d.idx = q.idx + IW'(1);
                    d.lo  = lim + AW'(1);
                end
            end
            S_EVAL: begin
                d.res = '0;
                if (p_remote) begin
                    d.res.remote = 1'b1;
                    d.res.node   = p_node;
                    d.rvalid     = 1'b1;
                    d.st         = S_IDLE;
                end else if (p_mode_err) begin
                    d.res.err = ERR_MODE;
                    d.rvalid  = 1'b1;
                    d.st      = S_IDLE;
                end else if (p_need_m3) begin
                    m3_start = 1'b1;
                    d.st     = S_FOLD;
                end else begin
                    d.res.lch = p_lch;
                    d.res.mc  = p_mc;
                    d.res.ch  = p_ch;
                    d.rvalid  = 1'b1;
                    d.st      = S_IDLE;
                end
                if (d.st == S_IDLE) d.idx = '0;
            end
            default: begin
                if (m3_done) begin
                    d.res     = '0;
                    d.res.lch = p_lch;
                    d.res.mc  = p_mc;
                    d.res.ch  = p_ch;
                    d.rvalid  = 1'b1;
                    d.idx     = '0;
                    d.st      = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == S_IDLE);
    assign rsp_valid  = q.rvalid;
    assign rsp_err    = q.res.err;
    assign rsp_remote = q.res.remote;
    assign rsp_node   = q.res.node;
    assign rsp_lch    = q.res.lch;
    assign rsp_mc     = q.res.mc;
    assign rsp_ch     = q.res.ch;
    assign rsp_entry  = q.rent;

    assert_one_inflight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready || rsp_valid);
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SCAN && $past(q.st) == S_SCAN) |-> (q.idx == $past(q.idx) + IW'(1)));
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.idx) < ENTRIES);
    assert_range_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == 2'd1) |-> $past(req_valid && req_ready));
    assert_remote_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_remote) |-> (rsp_err == 2'd0));
endmodule

// File: tb/sim_sysaddr_decode.sv
module sim_sysaddr_decode;
    import sad_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N = 24;

    logic        clk, rst_n, wr_en, req_valid, req_ready, rsp_valid, rsp_remote;
    logic [2:0]  wr_kind, rsp_node, rsp_lch, rsp_mc;
    logic [4:0]  wr_idx, rsp_entry;
    logic [31:0] wr_data;
    logic [45:0] req_addr;
    logic [1:0]  rsp_err, rsp_ch;

    logic [31:0] sh_ent [N];
    logic [31:0] sh_tgt [N];
    logic [31:0] sh_route;
    longint unsigned sh_low, sh_high;
    int checks, errors;

    sysaddr_decode u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_remote(rsp_remote), .rsp_node(rsp_node),
        .rsp_lch(rsp_lch), .rsp_mc(rsp_mc), .rsp_ch(rsp_ch), .rsp_entry(rsp_entry)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] k, input int i, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = i[4:0]; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        case (k)
            3'd0: sh_ent[i] = v;
            3'd1: sh_tgt[i] = v;
            3'd2: sh_route  = v;
            3'd3: sh_low    = longint'(v[19:0]);
            3'd4: sh_high   = longint'(v[19:0]);
            default: ;
        endcase
    endtask

    // {err, remote, node, lch, mc, ch, entry}
    function automatic logic [18:0] model(input longint unsigned a);
        longint unsigned lo, lim, e, v;
        logic [63:0] r64;
        int hit, im, sh, idx, t, sm, sub, b, lch, mc, ch;
        if (a >= (sh_high << 26) || (a >= (sh_low << 26) && a < 64'h1_0000_0000))
            return {2'd1, 17'd0};
        lo = 0; hit = -1;
        for (int i = 0; i < N; i++) begin
            e = longint'(sh_ent[i]);
            lim = (((e >> 7) & 64'hFFFFF) << 26) | 64'h3FFFFFF;
            if (sh_ent[i][0] && a >= lo && a <= lim) begin
                hit = i;
                break;
            end
            lo = lim + 1;
        end
        if (hit < 0) return {2'd2, 17'd0};
        im  = int'(sh_ent[hit][2:1]);
        sh  = (im == 0) ? 6 : (im == 1) ? 8 : (im == 2) ? 12 : 30;
        idx = int'((a >> sh) & 7);
        t   = int'((longint'(sh_tgt[hit]) >> (4 * idx)) & 15);
        if (t < 8) return {2'd0, 1'b1, 3'(t), 3'd0, 3'd0, 2'd0, 5'(hit)};
        if (!sh_ent[hit][27]) begin
            lch = t % 8;
        end else begin
            sm = int'(sh_ent[hit][31:30]);
            if (sm == 3) return {2'd3, 1'b0, 3'd0, 3'd0, 3'd0, 2'd0, 5'(hit)};
            sh  = (sm == 0) ? 6 : (sm == 1) ? 8 : 12;
            v   = a >> sh;
            sub = int'(sh_ent[hit][6:5]);
            case (sub)
                0: b = int'(v % 3);
                1: b = int'(v % 2);
                2: b = (v % 2 == 1) ? 2 : 1;
                default: b = int'(v % 2) * 2;
            endcase
            lch = (b * 2 + t % 2) % 8;
        end
        r64 = {32'd0, sh_route};
        mc  = int'((r64 >> (3 * lch)) & 7);
        ch  = int'((r64 >> (2 * lch + 18)) & 3);
        return {2'd0, 1'b0, 3'd0, 3'(lch), 3'(mc), 2'(ch), 5'(hit)};
    endfunction

    task automatic req(input string tag, input longint unsigned a);
        logic [18:0] exp, act;
        int n;
        logic busy_ok;
        exp = model(a);
        busy_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a[45:0];
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        act = {rsp_err, rsp_remote, rsp_node, rsp_lch, rsp_mc, rsp_ch, rsp_entry};
        chk(tag, act, exp, "result");
        chk("R11", busy_ok, 1, "ready low while busy");
        @(negedge clk);
        chk("R11", rsp_valid, 0, "single-cycle strobe");
        chk("R11", {rsp_err, rsp_remote, rsp_node, rsp_lch, rsp_mc, rsp_ch, rsp_entry},
            exp, "result held");
    endtask

    task automatic base_setup();
        wr(3'd3, 0, 32'd32);
        wr(3'd4, 0, 32'd256);
        wr(3'd0, 0, (32'd7 << 7) | 32'd1);
        wr(3'd0, 1, (32'd15 << 7));
        wr(3'd0, 2, (32'd31 << 7) | (32'd1 << 1) | 32'd1 | (32'd1 << 27));
        wr(3'd0, 3, (32'hBF << 7) | (32'd2 << 1) | 32'd1);
        wr(3'd1, 0, 32'hFEDC_BA98);
        wr(3'd1, 2, 32'h3C9B_0FA8);
        wr(3'd1, 3, 32'h7E5D_C4B1);
        wr(3'd2, 0, 32'hB5E3_9A47);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tg;
        checks = 0; errors = 0;
        for (int i = 0; i < N; i++) begin sh_ent[i] = '0; sh_tgt[i] = '0; end
        sh_route = '0; sh_low = 0; sh_high = 0;
        rst_n = 1'b0; wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
        req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", req_ready, 1, "ready after reset");
        chk("R12", rsp_valid, 0, "no result after reset");
        req("R12", 64'h0);
        req("R12", 64'h1234_5678);

        base_setup();

        // R7: entry 0, no fold, every interleave nibble
        for (int k = 0; k < 64; k++) req("R7", longint'(k) * 64 + longint'(k % 7));

        // R9: entry 2, modulo-3 fold on shift 6, interleave bits 10:8
        for (int k = 0; k < 48; k++)
            req("R9", 64'h4000_0000 + longint'(k) * 64'h140 + longint'(k * 3));

        // R2: disabled entry 1 window and first-match boundaries
        req("R2", 64'h2000_0000);
        req("R2", 64'h2ABC_DEF0);
        req("R2", 64'h3FFF_FFFF);
        req("R2", 64'h4000_0000);
        req("R3", 64'h1FFF_FFFF);
        req("R3", 64'h7FFF_FFFF);

        // R1 and R4: hole, top of memory, beyond last limit
        req("R1", 64'h8000_0000);
        req("R1", 64'hFFFF_FFFF);
        req("R1", 64'h4_0000_0000);
        req("R1", 64'h1_0000_0000);
        req("R4", 64'h3_0000_0000);
        req("R4", 64'h3_FFFF_FFFF);

        // R3: shrink entry 0 limit field to 3
        wr(3'd0, 0, (32'd3 << 7) | 32'd1);
        req("R3", 64'h0FFF_FFFF);
        req("R3", 64'h1000_0000);
        wr(3'd0, 0, (32'd7 << 7) | 32'd1);

        // R5, R8, R9: every interleave, fold shift and sub-mode on entry 3
        for (int im = 0; im < 4; im++)
            for (int sm = 0; sm < 4; sm++)
                for (int sb = 0; sb < 4; sb++)
                    for (int m3 = 0; m3 < 2; m3++) begin
                        wr(3'd0, 3, (32'hBF << 7) | 32'(im << 1) | 32'd1 |
                           32'(m3 << 27) | 32'(sm << 30) | 32'(sb << 5));
                        tg = (m3 == 1 && sm == 3) ? "R8" : (m3 == 1) ? "R9" : "R5";
                        for (int j = 0; j < 8; j++)
                            req(tg, 64'h1_0000_0000 + longint'(j) * 64'h3456_7EC4);
                    end

        // R10: every logical channel against several route words
        for (int k = 0; k < 8; k++) begin
            wr(3'd2, 0, 32'h9E37_79B9 * 32'(k + 1));
            for (int i = 0; i < 8; i++) req("R10", longint'(i) * 64);
        end

        // R6: all targets remote on entry 0
        wr(3'd1, 0, 32'h0123_4567);
        for (int i = 0; i < 8; i++) req("R6", longint'(i) * 64 + 3);
        wr(3'd1, 0, 32'hFEDC_BA98);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule